// File: doc/BRIEF.md
# SD Card Command-Line Transaction Engine

This block carries out one complete exchange on the single-wire command line of an SD/MMC card. A write strobe on the argument input starts it. At that moment the block takes the 32-bit argument and the configuration word presented beside it. It then shifts out a 48-bit command frame that carries its own CRC7. After the frame it releases the line. Depending on the configuration, it either finishes at once or waits for the card to answer with a 48-bit or a 136-bit reply.

The configuration also chooses three optional steps for each command. The first verifies the reply CRC. The second compares the echoed command index with the one that was sent. The third holds the completion until the card lets data line 0 go high again. A single watchdog, counted in card clock cycles, limits the whole exchange from the strobe onward. The reply payload is kept in four 32-bit words. The outcome is reported as one-cycle event pulses: completion, timeout, CRC error and index error. One clock cycle of `clk` is one card clock bit period.

Top module: `sdcmd_ctl`

## Requirements
- R1: After reset, `cmd_oe` is low, `cmd_out` is high, all four response words read zero and no event pulses.
- R2: A strobe on `arg_wr` while idle is accepted at that clock edge. `cmd_oe` is then high for exactly 48 consecutive cycles, beginning in the cycle after the accepting edge, unless the watchdog ends the transaction first.
- R3: The frame is sent MSB first as: 0, 1, the index `cmd_cfg[10:5]`, the 32-bit argument, the CRC7 (x^7+x^3+1, zero start value) of the preceding 40 bits, and a final 1.
- R4: `cmd_cfg[1:0]` selects the reply. 0 means none, 1 means a 48-bit reply, 2 means a 136-bit reply, and 3 behaves as 0. Without a reply and without a busy wait, `ev_done` pulses right after the frame.
- R5: When a reply is expected, the line stays released (`cmd_oe` low, `cmd_out` high) after the frame. The first low bit sampled on `cmd_in` is taken as the reply's start bit, however many idle cycles come before it.
- R6: For a 48-bit reply, word 0 gets reply bits 39:8 and the other words keep their values. For a 136-bit reply, the 120 bits 127:8 are stored with bit 8 at word 0 bit 0, so word 3 holds bits 127:104 in its low 24 bits and zeros above them.
- R7: When `cmd_cfg[3]` is set, the CRC7 of reply bits 47:8 (48-bit) or 127:8 (136-bit) is compared with reply bits 7:1. A mismatch pulses `ev_crc_err` instead of `ev_done`. When the bit is clear, a bad CRC goes unnoticed.
- R8: When `cmd_cfg[4]` is set and the reply is 48 bits long, reply bits 45:40 are compared with the sent index. A mismatch pulses `ev_idx_err` instead of `ev_done`. For 136-bit replies this check is never made.
- R9: When `cmd_cfg[2]` is set, `ev_done` is withheld after a frame with no reply, or after a clean reply, until `dat0_in` is sampled high.
- R10: If the transaction is still running `timeout_lim`+1 clock edges after the accepting edge, it is abandoned at that edge. `ev_timeout` pulses in the following cycle, no other event is raised and the line is released.
- R11: A strobe on `arg_wr` while a transaction is running is ignored: the frame in flight is unchanged and no second transaction follows.
- R12: Each event is a one-cycle pulse. `ev_done`, `ev_timeout` and the error pair never coincide, and no event pulses while `cmd_oe` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Card bit clock |
| rst | input | 1 | Synchronous active-high reset |
| arg_wr | input | 1 | Argument write strobe; starts a transaction when idle |
| arg_data | input | 32 | Command argument |
| cmd_cfg | input | 11 | [1:0] reply kind, [2] busy wait, [3] CRC check, [4] index check, [10:5] command index |
| timeout_lim | input | TO_W | Watchdog limit in clock cycles |
| cmd_in | input | 1 | Sampled command line |
| dat0_in | input | 1 | Sampled data line 0 (low means busy) |
| cmd_out | output | 1 | Command line drive value |
| cmd_oe | output | 1 | Command line drive enable |
| resp_w0 | output | 32 | Response word 0 (least significant) |
| resp_w1 | output | 32 | Response word 1 |
| resp_w2 | output | 32 | Response word 2 |
| resp_w3 | output | 32 | Response word 3 (most significant) |
| ev_done | output | 1 | Successful completion pulse |
| ev_timeout | output | 1 | Watchdog expiry pulse |
| ev_crc_err | output | 1 | Reply CRC mismatch pulse |
| ev_idx_err | output | 1 | Reply index mismatch pulse |

## Verification
A shared bit counter that slips shows up within the same frame. The drive enable then stays high for the wrong number of cycles, and the serial bits captured from `cmd_out` no longer match the frame the bench builds from index and argument. A fault in the reply side shows at the next event. A wrong CRC window or a misaligned shift register turns expected completions into CRC errors, or puts the payload into the wrong word, and this is visible as soon as the event pulse arrives. Watchdog faults are pinned to the exact cycle of the timeout pulse, measured from the strobe, so an off-by-one count is seen at once.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

    localparam int FRAME_LEN   = 48;
    localparam int LONG_LEN    = 136;
    localparam int CRC_W       = 7;
    localparam int IDX_W       = 6;
    localparam int ARG_W       = 32;
    localparam int WORD_W      = 32;
    localparam int RESP_WORDS  = 4;
    localparam int SHORT_SPAN  = 40;
    localparam int LONG_LO     = 8;
    localparam int LONG_HI     = 127;
    localparam int RX_W        = 128;
    localparam int HDR_W       = 8;
    localparam int IDX_LSB     = 40;
    localparam int POS_W       = $clog2(LONG_LEN);

    typedef enum logic [1:0] {
        RSP_NONE  = 2'd0,
        RSP_SHORT = 2'd1,
        RSP_LONG  = 2'd2,
        RSP_RSVD  = 2'd3
    } rsp_kind_e;

    typedef struct packed {
        logic [IDX_W-1:0] index;
        logic             chk_idx;
        logic             chk_crc;
        logic             wait_busy;
        rsp_kind_e        kind;
    } cmd_cfg_t;

    localparam int CFG_W = $bits(cmd_cfg_t);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEND,
        ST_WAIT,
        ST_RECV,
        ST_CHECK,
        ST_BUSY
    } ctl_state_e;

    // One serial step of the CRC7 generator x^7 + x^3 + 1.
    function automatic logic [CRC_W-1:0] crc7_step(logic [CRC_W-1:0] c, logic b);
        logic fb;
        fb = b ^ c[CRC_W-1];
        return {c[5:3], c[2] ^ fb, c[1:0], fb};
    endfunction

    function automatic logic [CRC_W-1:0] crc7_over(logic [SHORT_SPAN-1:0] bits);
        logic [CRC_W-1:0] c;
        c = '0;
        for (int i = SHORT_SPAN - 1; i >= 0; i--) begin
            c = crc7_step(c, bits[i]);
        end
        return c;
    endfunction

    function automatic logic [FRAME_LEN-1:0] build_frame(logic [IDX_W-1:0] idx,
                                                         logic [ARG_W-1:0] arg);
        logic [SHORT_SPAN-1:0] head;
        head = {2'b01, idx, arg};
        return {head, crc7_over(head), 1'b1};
    endfunction

endpackage

// File: rtl/sdcmd_tx.sv
module sdcmd_tx #(
    parameter int LEN = 48
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           load,
    input  logic [LEN-1:0] frame,
    input  logic           shift,
    output logic           out_bit
);
    logic [LEN-1:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q <= '1;
        end else if (load) begin
            sh_q <= frame;
        end else if (shift) begin
            sh_q <= {sh_q[LEN-2:0], 1'b1};
        end
    end

    assign out_bit = sh_q[LEN-1];
endmodule

// File: rtl/sdcmd_crc7.sv
module sdcmd_crc7
    import sdcmd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             en,
    input  logic             din,
    output logic [CRC_W-1:0] crc
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            crc <= '0;
        end else if (en) begin
            crc <= crc7_step(crc, din);
        end
    end
endmodule

// File: rtl/sdcmd_watchdog.sv
module sdcmd_watchdog #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic         run,
    input  logic [W-1:0] limit,
    output logic         expired
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || start) begin
            cnt_q <= '0;
        end else if (run && cnt_q != '1) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired = run && (cnt_q == limit);
endmodule

// File: rtl/sdcmd_ctl.sv
module sdcmd_ctl
    import sdcmd_pkg::*;
#(
    parameter int TO_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              arg_wr,
    input  logic [ARG_W-1:0]  arg_data,
    input  logic [CFG_W-1:0]  cmd_cfg,
    input  logic [TO_W-1:0]   timeout_lim,
    input  logic              cmd_in,
    input  logic              dat0_in,
    output logic              cmd_out,
    output logic              cmd_oe,
    output logic [WORD_W-1:0] resp_w0,
    output logic [WORD_W-1:0] resp_w1,
    output logic [WORD_W-1:0] resp_w2,
    output logic [WORD_W-1:0] resp_w3,
    output logic              ev_done,
    output logic              ev_timeout,
    output logic              ev_crc_err,
    output logic              ev_idx_err
);
    ctl_state_e                      state_q;
    cmd_cfg_t                        cfg_q;
    cmd_cfg_t                        cfg_in;
    logic [POS_W-1:0]                pos_q;
    logic [POS_W-1:0]                rsp_last;
    logic [RX_W-1:0]                 rx_q;
    logic [RX_W-1:0]                 resp_flat;
    logic [CRC_W-1:0]                rx_crc;
    logic [FRAME_LEN-1:0]            tx_frame;
    logic [RESP_WORDS-1:0][WORD_W-1:0] resp_q;
    logic tx_bit, wd_expired, accept, in_span, crc_clr, crc_en;
    logic is_long, crc_bad, idx_bad, store, active, sending;

    assign cfg_in    = cmd_cfg_t'(cmd_cfg);
    assign accept    = (state_q == ST_IDLE) && arg_wr;
    assign tx_frame  = build_frame(cfg_in.index, arg_data);
    assign active    = (state_q != ST_IDLE);
    assign sending   = (state_q == ST_SEND);
    assign is_long   = (cfg_q.kind == RSP_LONG);
    assign rsp_last  = is_long ? POS_W'(LONG_LEN - 1) : POS_W'(FRAME_LEN - 1);

    // Serial command frame
    sdcmd_tx #(.LEN(FRAME_LEN)) u_tx (
        .clk     (clk),
        .rst     (rst),
        .load    (accept),
        .frame   (tx_frame),
        .shift   (sending),
        .out_bit (tx_bit)
    );

    assign cmd_oe  = sending;
    assign cmd_out = sending ? tx_bit : 1'b1;

    // One watchdog spans the whole transaction
    sdcmd_watchdog #(.W(TO_W)) u_wd (
        .clk     (clk),
        .rst     (rst),
        .start   (accept),
        .run     (active),
        .limit   (timeout_lim),
        .expired (wd_expired)
    );

    // Running CRC over the covered part of the reply
    assign in_span = is_long ? (pos_q >= POS_W'(LONG_LO) && pos_q <= POS_W'(LONG_HI))
                             : (pos_q < POS_W'(SHORT_SPAN));
    assign crc_clr = (state_q == ST_WAIT) && !cmd_in;
    assign crc_en  = (state_q == ST_RECV) && in_span;

    sdcmd_crc7 u_crc (
        .clk (clk),
        .rst (rst),
        .clr (crc_clr),
        .en  (crc_en),
        .din (cmd_in),
        .crc (rx_crc)
    );

    assign crc_bad = cfg_q.chk_crc && (rx_crc != rx_q[CRC_W:1]);
    assign idx_bad = cfg_q.chk_idx && (cfg_q.kind == RSP_SHORT)
                     && (rx_q[IDX_LSB +: IDX_W] != cfg_q.index);
    assign store   = (state_q == ST_CHECK) && !wd_expired;

    // Control sequence
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            cfg_q      <= '0;
            pos_q      <= '0;
            rx_q       <= '0;
            ev_done    <= 1'b0;
            ev_timeout <= 1'b0;
            ev_crc_err <= 1'b0;
            ev_idx_err <= 1'b0;
        end else begin
            ev_done    <= 1'b0;
            ev_timeout <= 1'b0;
            ev_crc_err <= 1'b0;
            ev_idx_err <= 1'b0;
            if (wd_expired) begin
                state_q    <= ST_IDLE;
                ev_timeout <= 1'b1;
            end else begin
                case (state_q)
                    ST_IDLE: begin
                        if (arg_wr) begin
                            cfg_q   <= cfg_in;
                            pos_q   <= '0;
                            state_q <= ST_SEND;
                        end
                    end
                    ST_SEND: begin
                        if (pos_q == POS_W'(FRAME_LEN - 1)) begin
                            pos_q <= '0;
                            if (cfg_q.kind == RSP_SHORT || cfg_q.kind == RSP_LONG) begin
                                state_q <= ST_WAIT;
                            end else if (cfg_q.wait_busy) begin
                                state_q <= ST_BUSY;
                            end else begin
                                state_q <= ST_IDLE;
                                ev_done <= 1'b1;
                            end
                        end else begin
                            pos_q <= pos_q + 1'b1;
                        end
                    end
                    ST_WAIT: begin
                        if (!cmd_in) begin
                            rx_q    <= '0;
                            pos_q   <= POS_W'(1);
                            state_q <= ST_RECV;
                        end
                    end
                    ST_RECV: begin
                        rx_q <= {rx_q[RX_W-2:0], cmd_in};
                        if (pos_q == rsp_last) begin
                            state_q <= ST_CHECK;
                        end else begin
                            pos_q <= pos_q + 1'b1;
                        end
                    end
                    ST_CHECK: begin
                        ev_crc_err <= crc_bad;
                        ev_idx_err <= idx_bad;
                        if (crc_bad || idx_bad) begin
                            state_q <= ST_IDLE;
                        end else if (cfg_q.wait_busy) begin
                            state_q <= ST_BUSY;
                        end else begin
                            state_q <= ST_IDLE;
                            ev_done <= 1'b1;
                        end
                    end
                    ST_BUSY: begin
                        if (dat0_in) begin
                            state_q <= ST_IDLE;
                            ev_done <= 1'b1;
                        end
                    end
                    default: state_q <= ST_IDLE;
                endcase
            end
        end
    end

    // Response words
    assign resp_flat = {{HDR_W{1'b0}}, rx_q[RX_W-1:HDR_W]};

    for (genvar w = 0; w < RESP_WORDS; w++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst) begin
                resp_q[w] <= '0;
            end else if (store) begin
                if (is_long) begin
                    resp_q[w] <= resp_flat[w*WORD_W +: WORD_W];
                end else if (w == 0) begin
                    resp_q[w] <= rx_q[HDR_W +: WORD_W];
                end
            end
        end
    end

    assign resp_w0 = resp_q[0];
    assign resp_w1 = resp_q[1];
    assign resp_w2 = resp_q[2];
    assign resp_w3 = resp_q[3];
endmodule

// File: rtl/sdcmd_ctl_chk.sv
module sdcmd_ctl_chk (
    input logic clk,
    input logic rst,
    input logic arg_wr,
    input logic cmd_oe,
    input logic cmd_out,
    input logic ev_done,
    input logic ev_timeout,
    input logic ev_crc_err,
    input logic ev_idx_err
);
    logic [7:0] oe_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            oe_run <= '0;
        end else if (cmd_oe) begin
            oe_run <= oe_run + 1'b1;
        end else begin
            oe_run <= '0;
        end
    end

    assert_oe_after_write_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(cmd_oe) |-> $past(arg_wr));

    assert_frame_len_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(cmd_oe) |-> (oe_run == 8'd48 || ev_timeout));

    assert_frame_max_R2: assert property (@(posedge clk) disable iff (rst)
        oe_run <= 8'd48);

    assert_start_bit_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(cmd_oe) |-> !cmd_out);

    assert_dir_bit_R3: assert property (@(posedge clk) disable iff (rst)
        (cmd_oe && oe_run == 8'd1) |-> cmd_out);

    assert_evt_excl_R12: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ev_done, ev_timeout, ev_crc_err | ev_idx_err}));

    assert_evt_idle_R12: assert property (@(posedge clk) disable iff (rst)
        (ev_done || ev_timeout || ev_crc_err || ev_idx_err) |-> !cmd_oe);

    assert_done_pulse_R12: assert property (@(posedge clk) disable iff (rst)
        ev_done |=> !ev_done);
endmodule

bind sdcmd_ctl sdcmd_ctl_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .arg_wr     (arg_wr),
    .cmd_oe     (cmd_oe),
    .cmd_out    (cmd_out),
    .ev_done    (ev_done),
    .ev_timeout (ev_timeout),
    .ev_crc_err (ev_crc_err),
    .ev_idx_err (ev_idx_err)
);

// File: tb/sdcmd_ctl_tb.sv
module sdcmd_ctl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int TO_W = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic arg_wr = 1'b0;
    logic [31:0] arg_data = '0;
    logic [10:0] cmd_cfg = '0;
    logic [TO_W-1:0] timeout_lim = 16'd1000;
    logic cmd_in = 1'b1;
    logic dat0_in = 1'b1;
    logic cmd_out, cmd_oe;
    logic [31:0] resp_w0, resp_w1, resp_w2, resp_w3;
    logic ev_done, ev_timeout, ev_crc_err, ev_idx_err;

    sdcmd_ctl #(.TO_W(TO_W)) u_dut (
        .clk(clk), .rst(rst), .arg_wr(arg_wr), .arg_data(arg_data),
        .cmd_cfg(cmd_cfg), .timeout_lim(timeout_lim), .cmd_in(cmd_in),
        .dat0_in(dat0_in), .cmd_out(cmd_out), .cmd_oe(cmd_oe),
        .resp_w0(resp_w0), .resp_w1(resp_w1), .resp_w2(resp_w2), .resp_w3(resp_w3),
        .ev_done(ev_done), .ev_timeout(ev_timeout),
        .ev_crc_err(ev_crc_err), .ev_idx_err(ev_idx_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    int pcyc = 0;
    int n_done = 0, n_to = 0, n_crc = 0, n_idx = 0, to_cyc = 0;
    logic [31:0] exp_w [4];

    always @(posedge clk) pcyc++;

    always @(negedge clk) begin
        if (ev_done)    n_done++;
        if (ev_crc_err) n_crc++;
        if (ev_idx_err) n_idx++;
        if (ev_timeout) begin n_to++; to_cyc = pcyc; end
    end

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic check(input bit ok, input string req, input string what,
                         input logic [135:0] act, input logic [135:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic clear_counts();
        n_done = 0; n_to = 0; n_crc = 0; n_idx = 0;
    endtask

    // Augmented-message polynomial division by 0x89
    function automatic logic [6:0] ref_crc(input logic [127:0] msg, input int n);
        logic [7:0] rem;
        rem = '0;
        for (int i = n + 6; i >= 0; i--) begin
            rem = {rem[6:0], (i >= 7) ? msg[i-7] : 1'b0};
            if (rem[7]) rem = rem ^ 8'h89;
        end
        return rem[6:0];
    endfunction

    function automatic logic [47:0] ref_frame(input logic [5:0] idx, input logic [31:0] arg);
        return {2'b01, idx, arg, ref_crc({88'b0, 2'b01, idx, arg}, 40), 1'b1};
    endfunction

    task automatic run_txn(input logic [5:0] idx, input logic [31:0] arg, input logic [1:0] kind,
                           input bit c_crc, input bit c_idx, input bit c_busy,
                           input bit bad_crc, input bit bad_idx, input int gap,
                           input int busy_hold, input bit dup);
        logic [47:0] got, ef;
        logic [135:0] rv;
        logic [119:0] body;
        logic [39:0] head;
        logic [6:0] rc;
        int len;
        bit exp_crc, exp_idx, exp_done, has_rsp;
        clear_counts();
        has_rsp = (kind == 2'd1 || kind == 2'd2);
        ef = ref_frame(idx, arg);
        dat0_in = (busy_hold > 0) ? 1'b0 : 1'b1;
        cmd_cfg = {idx, c_idx, c_crc, c_busy, kind};
        arg_data = arg;
        arg_wr = 1'b1;
        got = '0;
        for (int b = 0; b < 48; b++) begin
            tick();
            arg_wr = 1'b0;
            if (dup && b == 10) begin
                arg_wr = 1'b1;
                arg_data = ~arg;
                cmd_cfg = {idx ^ 6'h2A, c_idx, c_crc, c_busy, kind};
            end
            if (!cmd_oe) begin
                check(0, "R2", "cmd_oe dropped inside frame", 136'(b), 136'd48);
                break;
            end
            got = {got[46:0], cmd_out};
        end
        arg_wr = 1'b0;
        tick();
        check(cmd_oe == 1'b0, "R2", "cmd_oe after 48 bits", 136'(cmd_oe), 136'd0);
        check(got == ef, dup ? "R11" : "R3", "frame bits", 136'(got), 136'(ef));
        if (has_rsp) begin
            for (int g = 0; g < gap; g++) tick();
            check(cmd_oe == 1'b0 && cmd_out == 1'b1, "R5", "line released while waiting",
                  136'({cmd_oe, cmd_out}), 136'b01);
            if (kind == 2'd2) begin
                body = {$urandom, $urandom, $urandom, $urandom};
                rc = ref_crc({8'b0, body}, 120) ^ (bad_crc ? 7'h05 : 7'h00);
                rv = {2'b00, 6'h3F ^ (bad_idx ? 6'h01 : 6'h00), body, rc, 1'b1};
                len = 136;
            end else begin
                head = {2'b00, idx ^ (bad_idx ? 6'h09 : 6'h00), $urandom};
                rc = ref_crc({88'b0, head}, 40) ^ (bad_crc ? 7'h40 : 7'h00);
                rv = {88'b0, head, rc, 1'b1};
                len = 48;
                body = '0;
            end
            for (int i = len - 1; i >= 0; i--) begin
                cmd_in = rv[i];
                tick();
            end
            cmd_in = 1'b1;
            if (kind == 2'd2) begin
                exp_w[0] = body[31:0];
                exp_w[1] = body[63:32];
                exp_w[2] = body[95:64];
                exp_w[3] = {8'h00, body[119:96]};
            end else begin
                exp_w[0] = head[31:0];
            end
        end
        exp_crc = has_rsp && c_crc && bad_crc;
        exp_idx = has_rsp && c_idx && (kind == 2'd1) && bad_idx;
        exp_done = !(exp_crc || exp_idx);
        if (busy_hold > 0) begin
            for (int h = 0; h < busy_hold; h++) tick();
            check(n_done == 0, "R9", "done while busy held", 136'(n_done), 136'd0);
            dat0_in = 1'b1;
        end
        for (int k = 0; k < 400 && (n_done + n_to + n_crc + n_idx) == 0; k++) tick();
        repeat (3) tick();
        if (dup) begin
            for (int k = 0; k < 60; k++) begin
                tick();
                if (cmd_oe) break;
            end
            check(cmd_oe == 1'b0, "R11", "second transaction started", 136'(cmd_oe), 136'd0);
        end
        check(n_done == int'(exp_done), (kind == 2'd0 || kind == 2'd3) ? "R4" : "R7", "done count",
              136'(n_done), 136'(exp_done));
        check(n_crc == int'(exp_crc), "R7", "crc error count", 136'(n_crc), 136'(exp_crc));
        check(n_idx == int'(exp_idx), "R8", "index error count", 136'(n_idx), 136'(exp_idx));
        check(n_to == 0, "R12", "spurious timeout", 136'(n_to), 136'd0);
        if (has_rsp) begin
            check({resp_w3, resp_w2, resp_w1, resp_w0} == {exp_w[3], exp_w[2], exp_w[1], exp_w[0]},
                  "R6", "response words", 136'({resp_w3, resp_w2, resp_w1, resp_w0}),
                  136'({exp_w[3], exp_w[2], exp_w[1], exp_w[0]}));
        end
    endtask

    task automatic run_to(input logic [1:0] kind, input bit busy, input int lim);
        int c0;
        clear_counts();
        timeout_lim = TO_W'(lim);
        dat0_in = busy ? 1'b0 : 1'b1;
        cmd_cfg = {6'h11, 1'b0, 1'b0, busy, kind};
        arg_data = 32'hCAFE_0001;
        arg_wr = 1'b1;
        c0 = pcyc;
        tick();
        arg_wr = 1'b0;
        for (int k = 0; k < lim + 80 && n_to == 0; k++) tick();
        repeat (3) tick();
        check(n_to == 1, "R10", "timeout count", 136'(n_to), 136'd1);
        check(to_cyc - c0 == lim + 2, "R10", "timeout cycle", 136'(to_cyc - c0), 136'(lim + 2));
        check(n_done + n_crc + n_idx == 0, "R10", "other events", 136'(n_done + n_crc + n_idx), 136'd0);
        check(cmd_oe == 1'b0, "R10", "line released", 136'(cmd_oe), 136'd0);
        dat0_in = 1'b1;
        timeout_lim = 16'd1000;
        repeat (2) tick();
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < 4; i++) exp_w[i] = '0;
        repeat (5) tick();
        rst = 1'b0;
        tick();
        // R1 reset state
        check(cmd_oe == 1'b0 && cmd_out == 1'b1, "R1", "line after reset",
              136'({cmd_oe, cmd_out}), 136'b01);
        check({resp_w3, resp_w2, resp_w1, resp_w0} == '0, "R1", "words after reset",
              136'({resp_w3, resp_w2, resp_w1, resp_w0}), 136'd0);
        check(n_done + n_to + n_crc + n_idx == 0, "R1", "events after reset",
              136'(n_done + n_to + n_crc + n_idx), 136'd0);

        // Directed corners
        run_txn(6'd0, 32'h0, 2'd0, 0, 0, 0, 0, 0, 0, 0, 0);           // R4 no reply
        run_txn(6'd9, 32'h1234_5678, 2'd3, 1, 1, 0, 0, 0, 0, 0, 0);   // R4 reserved kind
        run_txn(6'd17, 32'hDEAD_BEEF, 2'd1, 1, 1, 0, 0, 0, 30, 0, 0); // R5 long gap
        run_txn(6'd2, 32'h0000_0001, 2'd2, 1, 1, 0, 0, 1, 3, 0, 0);   // R8 long ignores index
        run_txn(6'd17, 32'hA5A5_A5A5, 2'd1, 0, 0, 0, 1, 1, 2, 0, 0);  // R7 checks disabled
        run_txn(6'd17, 32'h5A5A_5A5A, 2'd1, 1, 1, 0, 1, 1, 2, 0, 0);  // R7 R8 both errors
        run_txn(6'd7, 32'h0F0F_0F0F, 2'd1, 1, 1, 1, 0, 0, 2, 15, 0);  // R9 busy after reply
        run_txn(6'd38, 32'h3333_3333, 2'd0, 0, 0, 1, 0, 0, 0, 12, 0); // R9 busy without reply
        run_txn(6'd55, 32'h7777_0000, 2'd1, 1, 1, 0, 0, 0, 1, 0, 1);  // R11 strobe while busy
        run_to(2'd1, 1'b0, 100);                                       // R10 no reply
        run_to(2'd0, 1'b0, 20);                                        // R10 during frame
        run_to(2'd0, 1'b1, 90);                                        // R10 busy held

        // Constrained random transactions
        for (int t = 0; t < 40; t++) begin
            logic [1:0] kd;
            kd = 2'($urandom % 3);
            run_txn(6'($urandom), $urandom, kd, 1'($urandom), 1'($urandom), 1'($urandom),
                    ($urandom % 4) == 0, ($urandom % 4) == 0, 1 + int'($urandom % 6), 0, 0);
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule